// File: doc/BRIEF.md
# Collision-Free Bank Exchange Network

The block moves P soft values per cycle between P parallel decoder processors and P memory banks, one frame of M time steps per half-iteration. An input crossbar steers each lane to a bank, a per-bank reorder buffer reshuffles that bank's M values in time, and an output crossbar steers banks back onto lanes. Every time step uses its own crossbar permutation, and every bank uses its own reorder sequence. Because the routing comes from a precomputed bank assignment, any interleaver passes through without two lanes ever reaching the same bank in one step.

In forward flow, lane i carries the variables of sub-block i in natural order, and each processor receives them in interleaved order. Reverse flow runs the same three stages in mirrored order and restores natural order. Each bank buffer has two halves of depth M. One half fills while the other drains, so frames stream back to back with a latency of one frame.

Routing comes from three tables. Software writes them while the network is empty. They hold the natural-side crossbar selects, the permuted-side crossbar selects and the per-bank reorder sequences.

Top module: `exn_net`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high. The tables reset to identity (lane i uses bank i, and the reorder is sequential), so a frame leaves exactly as it entered.
- R2: With dir_i=0, input beat j lane i carries variable i*M+j (0-based), and output beat j lane i carries variable pi(i*M+j).
- R3: With dir_i=1, input beat j lane i carries variable pi(i*M+j), and output beat j lane i carries variable i*M+j, so the reverse pass restores the forward input order.
- R4: When the network is empty, a frame's first output beat is valid in the cycle after its last input beat is accepted. Two complete frames can be held. in_ready_o drops only when both halves are full, and out_valid_o is then high.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o does not change.
- R6: On every accepted input beat, each bank is driven by exactly one lane. On every accepted output beat, each lane reads a distinct bank.
- R7: A table write is ignored unless both halves are empty and no frame is partly written.
- R8: Table encoding. cfg_tbl_i=0 is the natural-side crossbar (row = step, col = lane, data = bank). 1 is the permuted-side crossbar with the same layout. 2 is the reorder table (row = bank, col = permuted-order step, data = natural-order step). A row or col out of range is ignored. Lane i occupies data bits [i*W +: W].
- R9: Direction is captured per frame, and frames of either direction may follow each other with no gap. dir_i must stay constant over a frame's M beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0 forward, 1 reverse |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted |
| in_data_i | input | P*W | P input lanes |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Output beat taken |
| out_data_o | output | P*W | P output lanes |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_tbl_i | input | 2 | Table select |
| cfg_row_i | input | CW | Table row |
| cfg_col_i | input | CW | Table column |
| cfg_data_i | input | CW | Table entry |

## Verification
A wrong table entry, a wrong reorder address or a half-pointer slip shows up as swapped or duplicated lane values. It appears in the first output frame that uses the bad entry, one frame after the beat that was stored wrongly. A stuck full flag shows within one frame, either as in_ready_o staying low or as output beats arriving in the wrong frame order. Both crossbar stages are also watched for two lanes claiming one bank on any step. Such a clash would otherwise show only as corrupted values in a later frame.

// File: rtl/exn_pkg.sv
`timescale 1ns/1ps
package exn_pkg;
  typedef enum logic [1:0] {
    TBL_NAT  = 2'd0,
    TBL_PERM = 2'd1,
    TBL_REORD = 2'd2
  } exn_tbl_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/exn_route_tbl.sv
`timescale 1ns/1ps
module exn_route_tbl #(
  parameter int P = 5,
  parameter int M = 5,
  localparam int LW = $clog2(P),
  localparam int SW = $clog2(M),
  localparam int CW = exn_pkg::max_int(LW, SW)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [1:0]           tbl_i,
  input  logic [CW-1:0]        row_i,
  input  logic [CW-1:0]        col_i,
  input  logic [CW-1:0]        data_i,
  output logic [M*P*LW-1:0]    nat_o,
  output logic [M*P*LW-1:0]    perm_o,
  output logic [P*M*SW-1:0]    reord_o
);
  import exn_pkg::*;

  logic [LW-1:0] nat_q   [M][P];
  logic [LW-1:0] perm_q  [M][P];
  logic [SW-1:0] reord_q [P][M];

  logic step_row_ok, lane_col_ok, bank_row_ok, step_col_ok;
  assign step_row_ok = int'(row_i) < M;
  assign lane_col_ok = int'(col_i) < P;
  assign bank_row_ok = int'(row_i) < P;
  assign step_col_ok = int'(col_i) < M;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < M; j++) begin
        for (int i = 0; i < P; i++) begin
          nat_q[j][i]   <= LW'(i);
          perm_q[j][i]  <= LW'(i);
          reord_q[i][j] <= SW'(j);
        end
      end
    end else if (we_i) begin
      case (exn_tbl_e'(tbl_i))
        TBL_NAT:
          if (step_row_ok && lane_col_ok)
            nat_q[row_i[SW-1:0]][col_i[LW-1:0]] <= data_i[LW-1:0];
        TBL_PERM:
          if (step_row_ok && lane_col_ok)
            perm_q[row_i[SW-1:0]][col_i[LW-1:0]] <= data_i[LW-1:0];
        TBL_REORD:
          if (bank_row_ok && step_col_ok)
            reord_q[row_i[LW-1:0]][col_i[SW-1:0]] <= data_i[SW-1:0];
        default: ;
      endcase
    end
  end

  for (genvar j = 0; j < M; j++) begin : g_step
    for (genvar i = 0; i < P; i++) begin : g_lane
      assign nat_o[(j*P+i)*LW +: LW]   = nat_q[j][i];
      assign perm_o[(j*P+i)*LW +: LW]  = perm_q[j][i];
      assign reord_o[(i*M+j)*SW +: SW] = reord_q[i][j];
    end
  end
endmodule

// File: rtl/exn_xbar.sv
`timescale 1ns/1ps
module exn_xbar #(
  parameter int P = 5,
  parameter int W = 8,
  parameter bit SCATTER = 1'b1,
  localparam int LW = $clog2(P)
) (
  input  logic [P*W-1:0]  data_i,
  input  logic [P*LW-1:0] sel_i,
  output logic [P*W-1:0]  data_o
);
  if (SCATTER) begin : g_scatter
    // input lane i drives output sel_i[i]
    always_comb begin
      data_o = '0;
      for (int i = 0; i < P; i++)
        for (int b = 0; b < P; b++)
          if (sel_i[i*LW +: LW] == LW'(b))
            data_o[b*W +: W] = data_o[b*W +: W] | data_i[i*W +: W];
    end
  end else begin : g_gather
    // output lane i reads input sel_i[i]
    always_comb begin
      data_o = '0;
      for (int i = 0; i < P; i++)
        for (int b = 0; b < P; b++)
          if (sel_i[i*LW +: LW] == LW'(b))
            data_o[i*W +: W] = data_o[i*W +: W] | data_i[b*W +: W];
    end
  end
endmodule

// File: rtl/exn_bank_buf.sv
`timescale 1ns/1ps
module exn_bank_buf #(
  parameter int M = 5,
  parameter int W = 8,
  localparam int SW = $clog2(M)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic          wr_half_i,
  input  logic [SW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_half_i,
  input  logic [SW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [2][M];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_half_i][wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_half_i][rd_addr_i];
endmodule

// File: rtl/exn_net.sv
`timescale 1ns/1ps
module exn_net #(
  parameter int P = 5,
  parameter int M = 5,
  parameter int W = 8,
  localparam int LW = $clog2(P),
  localparam int SW = $clog2(M),
  localparam int CW = exn_pkg::max_int(LW, SW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dir_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [P*W-1:0]  in_data_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [P*W-1:0]  out_data_o,
  input  logic            cfg_we_i,
  input  logic [1:0]      cfg_tbl_i,
  input  logic [CW-1:0]   cfg_row_i,
  input  logic [CW-1:0]   cfg_col_i,
  input  logic [CW-1:0]   cfg_data_i
);
  localparam int ROWW = P*LW;
  localparam logic [SW-1:0] LAST = SW'(M-1);

  logic [SW-1:0] wcnt_q, rcnt_q;
  logic          wsel_q, rsel_q;
  logic [1:0]    full_q, full_d, hdir_q;
  logic          in_fire, out_fire, rd_dir, idle, cfg_en;

  logic [M*P*LW-1:0] nat_tbl, perm_tbl;
  logic [P*M*SW-1:0] reord_tbl;
  logic [ROWW-1:0]   in_sel, out_sel;
  logic [P*W-1:0]    wr_bus, rd_bus;

  assign in_ready_o  = ~full_q[wsel_q];
  assign in_fire     = in_valid_i & in_ready_o;
  assign out_valid_o = full_q[rsel_q];
  assign out_fire    = out_valid_o & out_ready_i;
  assign rd_dir      = hdir_q[rsel_q];
  assign idle        = (full_q == 2'b00) && (wcnt_q == '0);
  assign cfg_en      = cfg_we_i & idle;

  exn_route_tbl #(.P(P), .M(M)) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_en),
    .tbl_i   (cfg_tbl_i),
    .row_i   (cfg_row_i),
    .col_i   (cfg_col_i),
    .data_i  (cfg_data_i),
    .nat_o   (nat_tbl),
    .perm_o  (perm_tbl),
    .reord_o (reord_tbl)
  );

  // reverse flow enters on the permuted side and leaves on the natural side
  assign in_sel  = dir_i  ? perm_tbl[int'(wcnt_q)*ROWW +: ROWW]
                          : nat_tbl[int'(wcnt_q)*ROWW +: ROWW];
  assign out_sel = rd_dir ? nat_tbl[int'(rcnt_q)*ROWW +: ROWW]
                          : perm_tbl[int'(rcnt_q)*ROWW +: ROWW];

  exn_xbar #(.P(P), .W(W), .SCATTER(1'b1)) u_xbar_in (
    .data_i (in_data_i),
    .sel_i  (in_sel),
    .data_o (wr_bus)
  );

  for (genvar b = 0; b < P; b++) begin : g_bank
    logic [SW-1:0] wr_addr, rd_addr;
    // forward: sequential write, permuted read; reverse: permuted write, sequential read
    assign wr_addr = dir_i  ? reord_tbl[(b*M + int'(wcnt_q))*SW +: SW] : wcnt_q;
    assign rd_addr = rd_dir ? rcnt_q : reord_tbl[(b*M + int'(rcnt_q))*SW +: SW];

    exn_bank_buf #(.M(M), .W(W)) u_buf (
      .clk_i     (clk_i),
      .wr_en_i   (in_fire),
      .wr_half_i (wsel_q),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_bus[b*W +: W]),
      .rd_half_i (rsel_q),
      .rd_addr_i (rd_addr),
      .rd_data_o (rd_bus[b*W +: W])
    );
  end

  exn_xbar #(.P(P), .W(W), .SCATTER(1'b0)) u_xbar_out (
    .data_i (rd_bus),
    .sel_i  (out_sel),
    .data_o (out_data_o)
  );

  always_comb begin
    full_d = full_q;
    if (in_fire && wcnt_q == LAST)  full_d[wsel_q] = 1'b1;
    if (out_fire && rcnt_q == LAST) full_d[rsel_q] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      rcnt_q <= '0;
      wsel_q <= 1'b0;
      rsel_q <= 1'b0;
      full_q <= '0;
      hdir_q <= '0;
    end else begin
      full_q <= full_d;
      if (in_fire) begin
        hdir_q[wsel_q] <= dir_i;
        if (wcnt_q == LAST) begin
          wcnt_q <= '0;
          wsel_q <= ~wsel_q;
        end else begin
          wcnt_q <= wcnt_q + SW'(1);
        end
      end
      if (out_fire) begin
        if (rcnt_q == LAST) begin
          rcnt_q <= '0;
          rsel_q <= ~rsel_q;
        end else begin
          rcnt_q <= rcnt_q + SW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/exn_net_chk.sv
`timescale 1ns/1ps
module exn_net_chk #(
  parameter int P = 5,
  parameter int M = 5,
  parameter int W = 8,
  localparam int LW = $clog2(P)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_ready_o,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [P*W-1:0]  out_data_o,
  input logic            in_fire_i,
  input logic [P*LW-1:0] in_sel_i,
  input logic [P*LW-1:0] out_sel_i
);
  function automatic logic lanes_distinct(input logic [P*LW-1:0] s);
    logic [P-1:0] hit;
    hit = '0;
    for (int i = 0; i < P; i++)
      if (int'(s[i*LW +: LW]) < P) hit = hit | (P'(1) << s[i*LW +: LW]);
    return &hit;
  endfunction

  // R5
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  // R6
  in_xbar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire_i |-> lanes_distinct(in_sel_i));

  // R6
  out_xbar_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |-> lanes_distinct(out_sel_i));

  // R4
  first_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_fire_i));

  // R4
  full_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |-> out_valid_o);
endmodule

bind exn_net exn_net_chk #(.P(P), .M(M), .W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .in_fire_i   (in_fire),
  .in_sel_i    (in_sel),
  .out_sel_i   (out_sel)
);

// File: tb/exn_net_tb_top.sv
`timescale 1ns/1ps
module exn_net_tb_top;
  localparam int P = 5, M = 5, W = 8, CW = 3, L = P*M;
  localparam int WD = 100000;

  logic clk_i = 1'b0, rst_ni = 1'b0, dir_i = 1'b0;
  logic in_valid_i = 1'b0, in_ready_o, out_valid_o, out_ready_i = 1'b0;
  logic [P*W-1:0] in_data_i = '0, out_data_o;
  logic cfg_we_i = 1'b0;
  logic [1:0] cfg_tbl_i = '0;
  logic [CW-1:0] cfg_row_i = '0, cfg_col_i = '0, cfg_data_i = '0;

  always #10 clk_i = ~clk_i;

  exn_net #(.P(P), .M(M), .W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .dir_i(dir_i),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_data_i(in_data_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .out_data_o(out_data_o),
    .cfg_we_i(cfg_we_i), .cfg_tbl_i(cfg_tbl_i), .cfg_row_i(cfg_row_i),
    .cfg_col_i(cfg_col_i), .cfg_data_i(cfg_data_i)
  );

  // bank per variable (row = sub-block, col = step) and interleaver, 0-based
  int map_t [L] = '{2,3,2,0,4, 0,1,3,1,2, 3,0,0,4,3, 1,4,1,3,0, 4,2,4,2,1};
  int pi_t  [L] = '{24,9,21,2,0, 13,10,4,5,1, 14,12,6,15,19, 23,17,7,18,16, 11,20,3,22,8};
  int pinv_t [L];
  int nat_t [M][P], perm_t [M][P], reord_t [P][M];

  int n_chk = 0, n_bad = 0, cyc = 0, mode = 0;
  logic [P*W-1:0] exp_q [$];
  string tag_q [$];
  logic r, hold_pend = 1'b0;
  logic [P*W-1:0] hold_data, e;
  string t;

  function automatic logic [W-1:0] val(input int fid, input int k);
    return W'(fid*37 + k*5 + 1);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // output side: ready pattern, stall hold (R5) and data compare on every transfer
  always @(negedge clk_i) begin
    cyc++;
    if (cyc > WD) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, WD);
      summary();
      $finish;
    end
    if (rst_ni) begin
      r = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 3 != 0) : 1'b0;
      if (hold_pend)
        check(out_valid_o && out_data_o == hold_data, "R5", 64'(out_data_o), 64'(hold_data));
      out_ready_i = r;
      hold_pend = out_valid_o && !r;
      hold_data = out_data_o;
      if (out_valid_o && r) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", 64'(out_data_o), 64'(0));
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data_o == e, t, 64'(out_data_o), 64'(e));
        end
      end
    end
  end

  task automatic cfg_write(input int tbl, input int row, input int col, input int d);
    cfg_we_i = 1'b1; cfg_tbl_i = 2'(tbl);
    cfg_row_i = CW'(row); cfg_col_i = CW'(col); cfg_data_i = CW'(d);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic send_frame(input bit rev, input int fid, input bit ident,
                            input bit lat, input int brk, input string tag);
    logic [P*W-1:0] ev, iv;
    for (int j = 0; j < M; j++) begin
      for (int i = 0; i < P; i++)
        ev[i*W +: W] = (ident || rev) ? val(fid, i*M+j) : val(fid, pi_t[i*M+j]);
      exp_q.push_back(ev);
      tag_q.push_back(tag);
    end
    dir_i = rev;
    @(negedge clk_i);
    for (int j = 0; j < M; j++) begin
      for (int i = 0; i < P; i++)
        iv[i*W +: W] = (rev && !ident) ? val(fid, pi_t[i*M+j]) : val(fid, i*M+j);
      in_valid_i = 1'b1;
      in_data_i = iv;
      while (!in_ready_o) @(negedge clk_i);
      if (lat && j == M-1) check(!out_valid_o, "R4", 64'(out_valid_o), 64'(0));
      @(negedge clk_i);
      if (lat && j == M-1) check(out_valid_o, "R4", 64'(out_valid_o), 64'(1));
      if (j == brk) begin
        // R7: would force a lane clash on step 3 if it took effect
        in_valid_i = 1'b0;
        cfg_write(0, 3, 0, nat_t[3][1]);
      end
    end
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    for (int k = 0; k < L; k++) pinv_t[pi_t[k]] = k;
    for (int j = 0; j < M; j++)
      for (int i = 0; i < P; i++) begin
        nat_t[j][i]  = map_t[i*M+j];
        perm_t[j][i] = map_t[pi_t[i*M+j]];
      end
    for (int k = 0; k < L; k++) reord_t[map_t[k]][pinv_t[k] % M] = k % M;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!out_valid_o, "R1", 64'(out_valid_o), 64'(0));
    check(in_ready_o, "R1", 64'(in_ready_o), 64'(1));
    send_frame(1'b0, 1, 1'b1, 1'b0, -1, "R1");
    drain();

    // R8: natural side, permuted side, reorder
    for (int j = 0; j < M; j++)
      for (int i = 0; i < P; i++) begin
        cfg_write(0, j, i, nat_t[j][i]);
        cfg_write(1, j, i, perm_t[j][i]);
        cfg_write(2, i, j, reord_t[i][j]);
      end

    send_frame(1'b0, 2, 1'b0, 1'b1, -1, "R2 R8");
    drain();
    send_frame(1'b1, 3, 1'b0, 1'b0, -1, "R3 R8");
    drain();

    mode = 1;
    send_frame(1'b0, 4, 1'b0, 1'b0, -1, "R6");
    send_frame(1'b1, 5, 1'b0, 1'b0, -1, "R9");
    send_frame(1'b0, 6, 1'b0, 1'b0, -1, "R9");
    drain();

    mode = 2;
    send_frame(1'b0, 7, 1'b0, 1'b0, -1, "R4");
    send_frame(1'b1, 8, 1'b0, 1'b0, -1, "R4");
    check(!in_ready_o, "R4", 64'(in_ready_o), 64'(0));
    check(out_valid_o, "R4", 64'(out_valid_o), 64'(1));
    mode = 0;
    drain();

    send_frame(1'b0, 9, 1'b0, 1'b0, 1, "R7");
    drain();
    send_frame(1'b0, 10, 1'b0, 1'b0, -1, "R7");
    drain();

    summary();
    $finish;
  end
endmodule